// File: doc/BRIEF.md
# Prioritised Chip Select Decoder

This block sits between a processor's 24-bit address bus and the memory and peripheral devices around it. On each valid access it picks exactly one destination: one of eight active-low external chip selects, the on-chip RAM, or the window of internal registers. Where two regions claim the same address, a fixed ranking settles it. The ranking depends on which regions are switched on: the on-chip RAM comes first, then the 32 KB low region, then the 4 MB region. The I/O page at 00:DFxx ranks above the upper 32 KB region of bank 0.

Each access also gets a speed. Some regions run on the full clock and others on the clock divided by four. A slow access is stretched by pulling `ready` low for a fixed number of extra cycles. The master holds the address and `acc_valid` until it sees `ready` high at a rising clock edge. The configuration inputs are static straps or register outputs that come from elsewhere in the chip.

Top module: `prio_sel_decoder`

## Requirements
- R1: While `acc_valid` is low, every `cs_n` bit is high and `iram_sel` and `ioreg_sel` are low.
- R2: At most one of the ten destinations (eight `cs_n` bits active low, `iram_sel`, `ioreg_sel`) is active in any cycle. Bit i of `cs_n` is external region i. `cs_n[2]` is reserved and always stays high.
- R3: Addresses 000000–0001FF raise `iram_sel` when `iram_off` is low. When `iram_off` is high, they fall through to region 3 if `region_en[3]` is set, otherwise to region 5 if `region_en[5]` is set.
- R4: Addresses 00DF80–00DFBF always raise `iram_sel` and never an external select, whatever the value of `iram_off`.
- R5: 00DF00–00DF1F drives `cs_n[0]` when `region_en[0]` is set. 00DFC0–00DFFF drives `cs_n[1]` when `region_en[1]` is set. When the matching enable is clear, those addresses raise `ioreg_sel` instead. 00DF20–00DF7F always raises `ioreg_sel`.
- R6: Bank 0 addresses below 8000 (other than the internal RAM) go to region 3 when `region_en[3]` is set, ahead of region 5.
- R7: Bank 0 addresses 8000–FFFF outside the DF page go to region 4 when `region_en[4]` is set, otherwise to region 5.
- R8: Banks 00–3F (where nothing above claims them) go to region 5. Banks 40–BF go to region 6 and banks C0–FF go to region 7. Each applies only while its `region_en` bit is set; otherwise no destination is active.
- R9: An access is slow when `force_slow` is high and some destination is active. Without `force_slow`, regions 4–7 follow `spd_fast[0]`–`spd_fast[3]`, and regions 0, 1, 3 and the internal registers follow `spd_rest_fast` (1 means full clock, 0 means divided by four). Internal RAM is slow only under `force_slow`.
- R10: A full-speed access, or a valid address with no active destination, has `ready` high in its first cycle.
- R11: A slow access holds `ready` low for its first 3 cycles and raises it in the 4th. Dropping `acc_valid` before then abandons the count, so the next slow access waits the full 3 cycles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 24 | Access address, bank in bits 23:16 |
| acc_valid | input | 1 | Access strobe, held until ready |
| region_en | input | 8 | Enable per external region, bit i = region i |
| iram_off | input | 1 | Disables the low internal RAM window |
| spd_fast | input | 4 | Full-speed bits for regions 4..7 |
| spd_rest_fast | input | 1 | Full-speed bit for all other regions |
| force_slow | input | 1 | Forces every access to divided clock |
| cs_n | output | 8 | Active-low external selects |
| iram_sel | output | 1 | On-chip RAM select |
| ioreg_sel | output | 1 | Internal register window select |
| ready | output | 1 | Access completes at a clock edge where high |

## Verification
The selects are decoded without any state, so a wrong priority or a wrong window edge shows at the ports in the same cycle as the address: either the wrong `cs_n` bit goes low, or two destinations go active together. The only state is the wait counter. If it is stuck or left uncleared, the bench sees `ready` come too early or too late, within at most four cycles of the start of a slow access. The bench also sees it on the access after an abandoned one, which then completes early.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

  localparam int N_EXT  = 8;
  localparam int N_SPD  = 4;
  localparam int SPD_LO = 4;

  typedef struct packed {
    logic [N_EXT-1:0] ext;
    logic             iram;
    logic             ioreg;
  } dest_t;

endpackage

// File: rtl/cs_region_decode.sv
module cs_region_decode
  import cs_dec_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic [N_EXT-1:0]  region_en,
  input  logic              iram_off,
  output dest_t             dest
);

  localparam int BANK_W = ADDR_W - 16;
  localparam logic [BANK_W-1:0] Q1_BANK = {2'b01, {(BANK_W-2){1'b0}}};
  localparam logic [BANK_W-1:0] Q3_BANK = {2'b11, {(BANK_W-2){1'b0}}};

  logic [BANK_W-1:0] bank;
  logic [15:0]       off;
  logic b0, low_ram, io_page, io_c0, io_ram, io_c1;
  logic lower_half, upper_half, zone5, zone6, zone7;

  assign bank = addr[ADDR_W-1:16];
  assign off  = addr[15:0];

  always_comb begin
    b0         = (bank == '0);
    low_ram    = b0 && (off[15:9] == 7'd0);
    io_page    = b0 && (off[15:8] == 8'hDF);
    io_c0      = io_page && (off[7:5] == 3'b000);
    io_ram     = io_page && (off[7:6] == 2'b10);
    io_c1      = io_page && (off[7:6] == 2'b11);
    lower_half = b0 && !off[15];
    upper_half = b0 && off[15] && !io_page;
    zone5      = (bank < Q1_BANK);
    zone6      = !zone5 && (bank < Q3_BANK);
    zone7      = (bank >= Q3_BANK);
  end

  always_comb begin
    dest = '0;
    if (valid) begin
      if (io_page) begin
        if (io_ram)                       dest.iram   = 1'b1;
        else if (io_c0 && region_en[0])   dest.ext[0] = 1'b1;
        else if (io_c1 && region_en[1])   dest.ext[1] = 1'b1;
        else                              dest.ioreg  = 1'b1;
      end else if (low_ram && !iram_off)  dest.iram   = 1'b1;
      else if (lower_half && region_en[3]) dest.ext[3] = 1'b1;
      else if (upper_half && region_en[4]) dest.ext[4] = 1'b1;
      else if (zone5 && region_en[5])     dest.ext[5] = 1'b1;
      else if (zone6 && region_en[6])     dest.ext[6] = 1'b1;
      else if (zone7 && region_en[7])     dest.ext[7] = 1'b1;
    end
  end

endmodule

// File: rtl/cs_speed_sel.sv
module cs_speed_sel
  import cs_dec_pkg::*;
(
  input  dest_t            dest,
  input  logic [N_SPD-1:0] spd_fast,
  input  logic             spd_rest_fast,
  input  logic             force_slow,
  output logic             slow
);

  logic [N_SPD-1:0] grp_slow;
  logic             rest_slow;
  logic             any_dest;

  for (genvar g = 0; g < N_SPD; g++) begin : g_grp
    assign grp_slow[g] = dest.ext[SPD_LO + g] && !spd_fast[g];
  end

  always_comb begin
    any_dest  = (|dest.ext) || dest.iram || dest.ioreg;
    rest_slow = ((|dest.ext[SPD_LO-1:0]) || dest.ioreg) && !spd_rest_fast;
    if (force_slow) slow = any_dest;
    else            slow = (|grp_slow) || rest_slow;
  end

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen #(
  parameter int WAIT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic slow,
  output logic ready
);

  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          slow_acc;

  assign slow_acc = valid && slow;
  assign ready    = !slow_acc || (cnt_q == LAST);

  always_comb begin
    cnt_en = slow_acc || (cnt_q != '0);
    if (slow_acc) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    else          cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_FIRST_CYCLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_acc && !$past(slow_acc)) |-> !ready); // R11

  AST_DONE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_acc && ready) |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/prio_sel_decoder.sv
module prio_sel_decoder
  import cs_dec_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WAIT_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_valid,
  input  logic [N_EXT-1:0]  region_en,
  input  logic              iram_off,
  input  logic [N_SPD-1:0]  spd_fast,
  input  logic              spd_rest_fast,
  input  logic              force_slow,
  output logic [N_EXT-1:0]  cs_n,
  output logic              iram_sel,
  output logic              ioreg_sel,
  output logic              ready
);

  dest_t dest;
  logic  slow;

  cs_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (acc_addr),
    .valid     (acc_valid),
    .region_en (region_en),
    .iram_off  (iram_off),
    .dest      (dest)
  );

  cs_speed_sel u_spd (
    .dest          (dest),
    .spd_fast      (spd_fast),
    .spd_rest_fast (spd_rest_fast),
    .force_slow    (force_slow),
    .slow          (slow)
  );

  cs_wait_gen #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (acc_valid),
    .slow  (slow),
    .ready (ready)
  );

  assign cs_n      = ~dest.ext;
  assign iram_sel  = dest.iram;
  assign ioreg_sel = dest.ioreg;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (&cs_n && !iram_sel && !ioreg_sel)); // R1

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~cs_n, iram_sel, ioreg_sel}) <= 1); // R2

  AST_FAST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !slow) |-> ready); // R10

  AST_CS3_OVER_CS5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region_en[3] && acc_addr[ADDR_W-1:15] == '0 &&
     (iram_off || acc_addr[14:9] != '0)) |-> (!cs_n[3] && cs_n[5])); // R6

endmodule

// File: tb/prio_sel_decoder_test.sv
module prio_sel_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [23:0] acc_addr;
  logic        acc_valid;
  logic [7:0]  region_en;
  logic        iram_off;
  logic [3:0]  spd_fast;
  logic        spd_rest_fast;
  logic        force_slow;
  logic [7:0]  cs_n;
  logic        iram_sel;
  logic        ioreg_sel;
  logic        ready;

  prio_sel_decoder uut (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_valid(acc_valid),
    .region_en(region_en), .iram_off(iram_off), .spd_fast(spd_fast),
    .spd_rest_fast(spd_rest_fast), .force_slow(force_slow),
    .cs_n(cs_n), .iram_sel(iram_sel), .ioreg_sel(ioreg_sel), .ready(ready)
  );

  typedef struct {
    logic [7:0] cs_n;
    logic       ir;
    logic       io;
    int         w;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   waits  = 0;
  bit   done   = 0;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic acc(input logic [23:0] a, input int sel, input logic eir,
                     input logic eio, input int ew, input string tag);
    exp_t e;
    e.cs_n = 8'hFF;
    if (sel >= 0) e.cs_n[sel] = 1'b0;
    e.ir = eir; e.io = eio; e.w = ew; e.tag = tag;
    @(negedge clk); #1;
    acc_addr  = a;
    acc_valid = 1'b1;
    sbq.push_back(e);
    wait (done);
    done = 0;
    @(negedge clk); #1;
    acc_valid = 1'b0;
  endtask

  // monitor: samples 2 ns before each rising edge
  initial begin
    forever begin
      @(posedge clk); #8;
      if (rst_n) begin
        if (acc_valid) begin
          if (!ready) waits++;
          else begin
            exp_t e;
            n_chk++;
            if (sbq.size() == 0) begin
              n_fail++;
              $display("FAIL unexpected completion act cs_n=%h exp none", cs_n);
            end else begin
              e = sbq.pop_front();
              if (cs_n !== e.cs_n || iram_sel !== e.ir || ioreg_sel !== e.io || waits != e.w) begin
                n_fail++;
                $display("FAIL %s addr=%h act cs_n=%h ir=%b io=%b waits=%0d exp cs_n=%h ir=%b io=%b waits=%0d",
                         e.tag, acc_addr, cs_n, iram_sel, ioreg_sel, waits, e.cs_n, e.ir, e.io, e.w);
              end
            end
            waits = 0;
            done  = 1;
          end
        end else begin
          waits = 0;
          n_chk++;
          if (cs_n !== 8'hFF || iram_sel !== 1'b0 || ioreg_sel !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 idle act cs_n=%h ir=%b io=%b exp cs_n=ff ir=0 io=0",
                     cs_n, iram_sel, ioreg_sel);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act hung exp completion");
    report();
  end

  task automatic dflt();
    region_en = 8'hFF; iram_off = 1'b0; spd_fast = 4'hF;
    spd_rest_fast = 1'b1; force_slow = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0;
    dflt();
    #12;
    n_chk++;
    if (cs_n !== 8'hFF || iram_sel !== 1'b0 || ioreg_sel !== 1'b0 || ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset act cs_n=%h ir=%b io=%b rdy=%b exp ff 0 0 1",
               cs_n, iram_sel, ioreg_sel, ready);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R3 low internal RAM and its fall-through
    acc(24'h000100, -1, 1, 0, 0, "R3 low iram");
    iram_off = 1;
    acc(24'h0001FF, 3, 0, 0, 0, "R3 iram off to cs3");
    region_en[3] = 0;
    acc(24'h000050, 5, 0, 0, 0, "R3 iram off to cs5");
    dflt();
    // R6
    acc(24'h000200, 3, 0, 0, 0, "R6 cs3 low edge");
    acc(24'h007FFF, 3, 0, 0, 0, "R6 cs3 top");
    region_en[3] = 0;
    acc(24'h007FFF, 5, 0, 0, 0, "R6 cs3 off gives cs5");
    dflt();
    // R4
    iram_off = 1;
    acc(24'h00DF90, -1, 1, 0, 0, "R4 upper iram with iram_off");
    dflt();
    acc(24'h00DFBF, -1, 1, 0, 0, "R4 upper iram top");
    // R5
    acc(24'h00DF10, 0, 0, 0, 0, "R5 cs0");
    acc(24'h00DFC5, 1, 0, 0, 0, "R5 cs1");
    acc(24'h00DF40, -1, 0, 1, 0, "R5 register window");
    acc(24'h00DF20, -1, 0, 1, 0, "R5 register window low edge");
    region_en[0] = 0; region_en[1] = 0;
    acc(24'h00DF1F, -1, 0, 1, 0, "R5 cs0 off to ioreg");
    acc(24'h00DFFF, -1, 0, 1, 0, "R5 cs1 off to ioreg");
    dflt();
    // R7
    acc(24'h008000, 4, 0, 0, 0, "R7 cs4 low edge");
    acc(24'h00DEFF, 4, 0, 0, 0, "R7 cs4 below io page");
    acc(24'h00FFFF, 4, 0, 0, 0, "R7 cs4 top");
    region_en[4] = 0;
    acc(24'h009000, 5, 0, 0, 0, "R7 cs4 off to cs5");
    dflt();
    // R8 and R2 (cs_n[2] never active)
    acc(24'h010000, 5, 0, 0, 0, "R8 cs5 bank1");
    acc(24'h3FFFFF, 5, 0, 0, 0, "R8 cs5 top");
    acc(24'h400000, 6, 0, 0, 0, "R8 cs6 low");
    acc(24'hBFFFFF, 6, 0, 0, 0, "R8 cs6 top");
    acc(24'hC00000, 7, 0, 0, 0, "R8 cs7 low");
    acc(24'hFFFFFF, 7, 0, 0, 0, "R8 cs7 top");
    region_en[5] = 0;
    acc(24'h200000, -1, 0, 0, 0, "R8 cs5 off none");
    dflt();
    region_en[7] = 0;
    acc(24'hE00000, -1, 0, 0, 0, "R8 cs7 off none");
    region_en[2] = 1;
    acc(24'h000300, 3, 0, 0, 0, "R2 cs2 stays high");
    dflt();
    // R9 R11 speeds
    spd_fast = 4'b1110;
    acc(24'h009000, 4, 0, 0, 3, "R9 R11 cs4 slow");
    acc(24'h500000, 6, 0, 0, 0, "R9 cs6 fast while cs4 slow");
    spd_fast = 4'b1011;
    acc(24'h800000, 6, 0, 0, 3, "R9 cs6 slow");
    acc(24'hF00000, 7, 0, 0, 0, "R9 cs7 fast");
    spd_fast = 4'b0111;
    acc(24'hF00000, 7, 0, 0, 3, "R9 cs7 slow");
    dflt();
    spd_rest_fast = 0;
    acc(24'h000300, 3, 0, 0, 3, "R9 rest slow cs3");
    acc(24'h00DF30, -1, 0, 1, 3, "R9 rest slow ioreg");
    acc(24'h000010, -1, 1, 0, 0, "R9 iram ignores rest bit");
    acc(24'h020000, 5, 0, 0, 0, "R9 cs5 ignores rest bit");
    dflt();
    force_slow = 1;
    acc(24'h000010, -1, 1, 0, 3, "R9 force slow iram");
    acc(24'hC00010, 7, 0, 0, 3, "R9 force slow cs7");
    region_en[7] = 0;
    acc(24'hFF0000, -1, 0, 0, 0, "R10 unmapped ready at once");
    dflt();
    // R11 abandoned access then full wait
    spd_fast = 4'b1110;
    @(negedge clk); #1;
    acc_addr = 24'h00A000; acc_valid = 1'b1;
    @(negedge clk); #1;
    acc_valid = 1'b0;
    @(negedge clk); #1;
    acc_addr = 24'h00A000; acc_valid = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #1;
    acc_valid = 1'b0;
    acc(24'h00A000, 4, 0, 0, 3, "R11 after abandoned access");
    acc(24'h00A004, 4, 0, 0, 3, "R11 back to back slow");
    dflt();
    acc(24'h00A000, 4, 0, 0, 0, "R10 cs4 fast");
    repeat (3) @(posedge clk);
    report();
  end

endmodule